// File: doc/BRIEF.md
# Serial Flash Erase Sequencer

This block takes an erase request, given as a start byte address and a byte length, and turns it into a series of erase commands for a page-organised serial flash. It sends those commands through a byte-level SPI master interface. A page need not hold a power-of-two number of bytes. For that reason the block first divides the address and the length by the configured page size, one bit per cycle, to get a start page index and a page count. It rejects any request that is misaligned or that runs past the end of the device.

For each step the block chooses between two erase commands. A block erase clears eight pages and is used when the current page index is a multiple of eight and at least eight pages are still left. Otherwise a single-page erase is used. The page index is shifted left by a configured amount to form the 24-bit flash address. After every erase the block polls the status byte until the device reports ready. Chip select is released for a programmable gap between any two transactions.

The SPI master attached below the block shifts one byte for each `xfer_go`/`xfer_done` handshake. It returns the top bit of the byte it received.

Top module: `flash_erase_seq`

## Requirements
- R1: A request whose start address or length is not a whole multiple of `cfg_page_size`, or whose start plus length exceeds `cfg_page_size` × `cfg_num_pages`, produces a one-cycle `err` pulse and no SPI transaction.
- R2: An aligned, in-range request of length zero produces a one-cycle `done` pulse and no SPI transaction.
- R3: The opcode of an erase command is 0x50 (eight-page erase) when the current page index has its three low bits at zero and at least eight pages remain; otherwise it is 0x81 (single-page erase).
- R4: After an eight-page erase the page index advances by eight, and after a single-page erase it advances by one. The commands of one request cover the requested pages in ascending order, each page exactly once.
- R5: An erase transaction has exactly four bytes, in this order: opcode, bits 23:16 of (page index << `cfg_page_shift`), bits 15:8 of the same value, then 0x00.
- R6: After each erase the block runs status transactions of two bytes each: 0xD7, then 0x00, with `xfer_rx_msb` of the second byte read as the ready flag. It repeats them until ready is 1. No further erase command and no `done` pulse occurs while the device is not ready.
- R7: Between two consecutive transactions of one request, `cs_n` stays high for exactly `cfg_poll_gap`+1 cycles. `cs_n` is high whenever `busy` is low.
- R8: `busy` rises in the cycle after a request is accepted. `done` and `err` are one-cycle pulses in the first cycle with `busy` low again, and they never occur together.
- R9: A `req_valid` seen while `busy` is high is ignored: it starts no second sequence and changes no command of the running one.
- R10: Page shifts of 9, 10 and 11, with page sizes of 264, 528 and 1056 bytes, give the addresses of R5.
- R11: Once `xfer_go` is raised for a byte, it stays high and `xfer_tx` stays stable until `xfer_done` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Erase request strobe, taken only while idle |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | ADDR_W | Length in bytes |
| cfg_page_size | input | PS_W | Bytes per page |
| cfg_page_shift | input | 4 | Left shift from page index to flash address |
| cfg_num_pages | input | NP_W | Number of pages in the device |
| cfg_poll_gap | input | GAP_W | Extra idle cycles with chip select released between transactions |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle pulse: range erased |
| err | output | 1 | One-cycle pulse: request rejected |
| cs_n | output | 1 | Chip select, active low |
| xfer_go | output | 1 | Byte transfer request to the SPI master |
| xfer_tx | output | 8 | Byte to transmit |
| xfer_done | input | 1 | One-cycle pulse: byte shifted |
| xfer_rx_msb | input | 1 | Bit 7 of the byte received in the acknowledged transfer |

## Verification
The hardest situation to reach is a long range that starts off an eight-page boundary. There the block must step through single-page erases up to the boundary, switch to eight-page erases, and fall back to single pages for the tail, while the device stays busy for a varying number of polls after each command. The bench's device model answers every erase with a random count of not-ready status bytes, and random low status bits that the block must ignore. Start pages are drawn both aligned and unaligned, for all three page geometries. Some requests also carry a second request strobe injected while the first is still running.

// File: rtl/flash_erase_seq.sv
module flash_erase_seq #(
  parameter int ADDR_W = 24,
  parameter int PS_W   = 12,
  parameter int NP_W   = 16,
  parameter int GAP_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ADDR_W-1:0] req_len,
  input  logic [PS_W-1:0]   cfg_page_size,
  input  logic [3:0]        cfg_page_shift,
  input  logic [NP_W-1:0]   cfg_num_pages,
  input  logic [GAP_W-1:0]  cfg_poll_gap,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              cs_n,
  output logic              xfer_go,
  output logic [7:0]        xfer_tx,
  input  logic              xfer_done,
  input  logic              xfer_rx_msb
);
  localparam int DIV_W = $clog2(ADDR_W) + 1;
  localparam int CNT_W = (GAP_W > DIV_W) ? GAP_W : DIV_W;
  localparam logic [7:0] OP_BLOCK = 8'h50;
  localparam logic [7:0] OP_PAGE  = 8'h81;
  localparam logic [7:0] OP_STAT  = 8'hD7;

  typedef enum logic [2:0] {S_IDLE, S_DIV, S_CHECK, S_CMD, S_GAP, S_POLL} state_t;
  state_t st;

  logic [ADDR_W-1:0] qa, ql;
  logic [PS_W-1:0]   ra, rl;
  logic [CNT_W-1:0]  cnt;
  logic [1:0]        idx;
  logic              rdy;

  logic [PS_W:0]     ta, tl;
  logic              ga, gl, blk;
  logic [15:0]       pa_hi;
  logic [ADDR_W:0]   span;
  logic [ADDR_W-1:0] step;

  assign ta    = {ra, qa[ADDR_W-1]};
  assign tl    = {rl, ql[ADDR_W-1]};
  assign ga    = ta >= {1'b0, cfg_page_size};
  assign gl    = tl >= {1'b0, cfg_page_size};
  assign span  = {1'b0, qa} + {1'b0, ql};
  assign blk   = (qa[2:0] == 3'd0) && (ql >= ADDR_W'(8));
  assign step  = blk ? ADDR_W'(8) : ADDR_W'(1);
  assign pa_hi = 16'((24'(qa) << cfg_page_shift) >> 8);

  assign busy    = st != S_IDLE;
  assign cs_n    = !(st == S_CMD || st == S_POLL);
  assign xfer_go = !cs_n;

  always_comb begin
    xfer_tx = 8'h00;
    if (st == S_CMD) begin
      case (idx)
        2'd0:    xfer_tx = blk ? OP_BLOCK : OP_PAGE;
        2'd1:    xfer_tx = pa_hi[15:8];
        2'd2:    xfer_tx = pa_hi[7:0];
        default: xfer_tx = 8'h00;
      endcase
    end else if (st == S_POLL && idx == 2'd0) begin
      xfer_tx = OP_STAT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      qa   <= '0;
      ql   <= '0;
      ra   <= '0;
      rl   <= '0;
      cnt  <= '0;
      idx  <= '0;
      rdy  <= 1'b0;
      done <= 1'b0;
      err  <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          qa  <= req_addr;
          ql  <= req_len;
          ra  <= '0;
          rl  <= '0;
          cnt <= '0;
          st  <= S_DIV;
        end
        S_DIV: begin
          qa  <= {qa[ADDR_W-2:0], ga};
          ql  <= {ql[ADDR_W-2:0], gl};
          ra  <= ta[PS_W-1:0] - (ga ? cfg_page_size : '0);
          rl  <= tl[PS_W-1:0] - (gl ? cfg_page_size : '0);
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(ADDR_W - 1)) st <= S_CHECK;
        end
        S_CHECK: begin
          if (ra != '0 || rl != '0 || span > (ADDR_W+1)'(cfg_num_pages)) begin
            err <= 1'b1;
            st  <= S_IDLE;
          end else if (ql == '0) begin
            done <= 1'b1;
            st   <= S_IDLE;
          end else begin
            idx <= '0;
            st  <= S_CMD;
          end
        end
        S_CMD: if (xfer_done) begin
          idx <= idx + 1'b1;
          if (idx == 2'd3) begin
            qa  <= qa + step;
            ql  <= ql - step;
            rdy <= 1'b0;
            cnt <= '0;
            st  <= S_GAP;
          end
        end
        S_GAP: begin
          if (cnt == CNT_W'(cfg_poll_gap)) begin
            idx <= '0;
            st  <= rdy ? S_CMD : S_POLL;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_POLL: if (xfer_done) begin
          if (idx == 2'd0) begin
            idx <= 2'd1;
          end else if (xfer_rx_msb && ql == '0) begin
            done <= 1'b1;
            st   <= S_IDLE;
          end else begin
            rdy <= xfer_rx_msb;
            cnt <= '0;
            st  <= S_GAP;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_erase_seq_chk.sv
module flash_erase_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       busy,
  input logic       done,
  input logic       err,
  input logic       cs_n,
  input logic       xfer_go,
  input logic [7:0] xfer_tx,
  input logic       xfer_done
);
  logic [2:0] bcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         bcnt <= '0;
    else if (cs_n)      bcnt <= '0;
    else if (xfer_done) bcnt <= bcnt + 1'b1;
  end

  assert_pulse_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err) |-> !busy);
  assert_one_outcome_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));
  assert_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));
  assert_cs_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_n);
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_go && !xfer_done) |=> (xfer_go && $stable(xfer_tx)));
  assert_first_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_go && bcnt == 3'd0) |-> (xfer_tx == 8'h50 || xfer_tx == 8'h81 || xfer_tx == 8'hD7));
  assert_cmd_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> bcnt < 3'd4);
endmodule

bind flash_erase_seq flash_erase_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy), .done(done),
  .err(err), .cs_n(cs_n), .xfer_go(xfer_go), .xfer_tx(xfer_tx), .xfer_done(xfer_done)
);

// File: tb/tb_flash_erase_seq.sv
module tb_flash_erase_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [23:0] req_addr = '0, req_len = '0;
  logic [11:0] cfg_page_size = 12'd264;
  logic [3:0]  cfg_page_shift = 4'd9;
  logic [15:0] cfg_num_pages = 16'd64;
  logic [7:0]  cfg_poll_gap = 8'd2;
  logic        busy, done, err, cs_n, xfer_go;
  logic [7:0]  xfer_tx;
  logic        xfer_done = 1'b0;
  logic [7:0]  rx_byte = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_erase_seq dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr), .req_len(req_len),
    .cfg_page_size(cfg_page_size), .cfg_page_shift(cfg_page_shift),
    .cfg_num_pages(cfg_num_pages), .cfg_poll_gap(cfg_poll_gap),
    .busy(busy), .done(done), .err(err), .cs_n(cs_n), .xfer_go(xfer_go), .xfer_tx(xfer_tx),
    .xfer_done(xfer_done), .xfer_rx_msb(rx_byte[7])
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // device model state
  logic [7:0] txb [0:7];
  int nb = 0, ntxn = 0, ncmd = 0, perr = 0, gap_err = 0, unstable = 0;
  int cs_hi_run = 0, busy_left = 0, wait_n = 0;
  bit in_txn = 0, fbusy = 0, seen_go = 0;
  logic [7:0] hold_tx = '0;
  logic [7:0] c_op [0:127];
  logic [7:0] c_a1 [0:127];
  logic [7:0] c_a2 [0:127];
  logic [7:0] c_a3 [0:127];

  task automatic finalize_txn();
    if (nb == 4 && (txb[0] == 8'h50 || txb[0] == 8'h81)) begin
      if (fbusy) perr++;
      if (ncmd < 128) begin
        c_op[ncmd] = txb[0]; c_a1[ncmd] = txb[1]; c_a2[ncmd] = txb[2]; c_a3[ncmd] = txb[3];
      end
      ncmd++;
      fbusy = 1;
      busy_left = $urandom_range(0, 3);
    end else if (nb == 2 && txb[0] == 8'hD7 && txb[1] == 8'h00) begin
    end else begin
      perr++;
    end
    nb = 0;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        xfer_done = 0; nb = 0; in_txn = 0; seen_go = 0;
      end else begin
        if (cs_n) begin
          if (in_txn) finalize_txn();
          in_txn = 0;
          cs_hi_run++;
        end else if (!in_txn) begin
          in_txn = 1;
          if (ntxn > 0 && cs_hi_run != int'(cfg_poll_gap) + 1) gap_err++;
          ntxn++;
          cs_hi_run = 0;
        end
        if (xfer_done) begin
          xfer_done = 0;
        end else if (xfer_go) begin
          if (!seen_go) begin
            seen_go = 1; hold_tx = xfer_tx; wait_n = $urandom_range(0, 2);
          end else if (xfer_tx != hold_tx) begin
            unstable++;
          end
          if (wait_n == 0) begin
            if (nb < 8) txb[nb] = xfer_tx;
            if (nb == 1 && txb[0] == 8'hD7) begin
              if (busy_left == 0) begin
                rx_byte = 8'h80 | 8'($urandom_range(0, 127));
                fbusy = 0;
              end else begin
                rx_byte = 8'($urandom_range(0, 127));
                busy_left--;
              end
            end else begin
              rx_byte = 8'($urandom_range(0, 255));
            end
            nb++;
            seen_go = 0;
            xfer_done = 1;
          end else begin
            wait_n--;
          end
        end
      end
    end
  end

  // expected command list
  logic [7:0] e_op [0:127];
  logic [7:0] e_a1 [0:127];
  logic [7:0] e_a2 [0:127];

  function automatic int build_exp(input int pi, input int pc, input int sh);
    int ne = 0;
    while (pc > 0) begin
      bit b = (pi % 8 == 0) && (pc >= 8);
      int a = (pi << sh) & 32'hFFFFFF;
      if (ne < 128) begin
        e_op[ne] = b ? 8'h50 : 8'h81;
        e_a1[ne] = 8'(a >> 16);
        e_a2[ne] = 8'(a >> 8);
      end
      ne++;
      pi += b ? 8 : 1;
      pc -= b ? 8 : 1;
    end
    return ne;
  endfunction

  task automatic run_req(input int addr, input int len, input bit inject, input string tag);
    int ps = int'(cfg_page_size);
    bit bad = (addr % ps != 0) || (len % ps != 0) || (addr + len > ps * int'(cfg_num_pages));
    int ne = bad ? 0 : build_exp(addr / ps, len / ps, int'(cfg_page_shift));
    int n = 0;
    bit got_done = 0, got_err = 0;
    ncmd = 0; ntxn = 0; perr = 0; gap_err = 0; unstable = 0; cs_hi_run = 0;
    @(negedge clk);
    req_addr = 24'(addr); req_len = 24'(len); req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    chk(busy == 1'b1, {"R8 busy after accept ", tag}, int'(busy), 1);
    forever begin
      if (inject && (n == 5 || n == 60)) begin
        req_valid = 1; req_addr = 24'(ps * 2); req_len = 24'(ps);
      end else begin
        req_valid = 0;
      end
      @(negedge clk);
      n++;
      if (done || err) begin
        got_done = done; got_err = err;
        chk(busy == 1'b0, {"R8 busy low at pulse ", tag}, int'(busy), 0);
        break;
      end
      if (n > 30000) begin
        chk(0, {"R8 watchdog no completion ", tag}, n, 30000);
        break;
      end
    end
    req_valid = 0;
    chk(got_err == bad && got_done == !bad, {"R1 R2 outcome ", tag}, int'(got_err), int'(bad));
    repeat (3) begin
      @(negedge clk);
      if (busy || done || err) begin
        chk(0, {"R9 activity after completion ", tag}, int'(busy), 0);
        break;
      end
    end
    if (bad) begin
      chk(ntxn == 0, {"R1 no transaction on reject ", tag}, ntxn, 0);
    end else begin
      if (len == 0) chk(ntxn == 0, {"R2 no transaction on zero length ", tag}, ntxn, 0);
      chk(ncmd == ne, {"R4 command count ", tag}, ncmd, ne);
      for (int i = 0; i < ncmd && i < ne && i < 128; i++) begin
        chk(c_op[i] == e_op[i], {"R3 opcode ", tag}, int'(c_op[i]), int'(e_op[i]));
        chk(c_a1[i] == e_a1[i] && c_a2[i] == e_a2[i] && c_a3[i] == 8'h00,
            {"R5 R10 address bytes ", tag}, {c_a1[i], c_a2[i], c_a3[i]}, {e_a1[i], e_a2[i], 8'h00});
      end
      chk(perr == 0 && !fbusy, {"R6 status polling ", tag}, perr, 0);
      chk(gap_err == 0, {"R7 chip select gap ", tag}, gap_err, 0);
      chk(unstable == 0, {"R11 byte held ", tag}, unstable, 0);
    end
  endtask

  task automatic set_geom(input int k, input int np, input int gap);
    cfg_page_size = 12'(264 << k);
    cfg_page_shift = 4'(9 + k);
    cfg_num_pages = 16'(np);
    cfg_poll_gap = 8'(gap);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "R8 global watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(busy == 0 && cs_n == 1 && xfer_go == 0 && done == 0 && err == 0,
        "R8 reset state", {busy, cs_n, xfer_go, done, err}, 5'b01000);
    rst_n = 1;
    @(negedge clk);

    set_geom(0, 64, 2);
    run_req(0, 20 * 264, 0, "aligned start");
    run_req(3 * 264, 14 * 264, 0, "unaligned start");
    set_geom(1, 64, 1);
    run_req(5 * 528, 12 * 528, 0, "shift10");
    set_geom(2, 64, 3);
    run_req(40 * 1056, 9 * 1056, 0, "shift11");
    set_geom(0, 64, 0);
    run_req(7 * 264, 3 * 264, 0, "gap zero");
    run_req(8 * 264, 0, 0, "zero length");
    run_req(64 * 264, 0, 0, "zero length at end");
    run_req(1, 264, 0, "misaligned start");
    run_req(264, 265, 0, "misaligned length");
    run_req(60 * 264, 5 * 264, 0, "past end");
    run_req(56 * 264, 8 * 264, 0, "exact fit at end");
    set_geom(1, 32, 2);
    run_req(2 * 528, 20 * 528, 1, "ignored request");

    for (int it = 0; it < 30; it++) begin
      int k = $urandom_range(0, 2);
      int np = $urandom_range(24, 48);
      int pi, pc, r, ps, addr, len;
      set_geom(k, np, $urandom_range(0, 4));
      ps = 264 << k;
      pi = $urandom_range(0, np);
      if ($urandom_range(0, 1) == 1) pi = pi & ~7;
      pc = $urandom_range(0, np - pi);
      r = $urandom_range(0, 9);
      addr = pi * ps;
      len = pc * ps;
      if (r == 0) addr += $urandom_range(1, ps - 1);
      if (r == 1) len += $urandom_range(1, ps - 1);
      if (r == 2) len = (np - pi + 1) * ps;
      run_req(addr, len, r == 3, "random");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule